// File: doc/BRIEF.md
# Trap-Control Register Access Gate

This block decides what happens when software reads or writes a fine-grained trap-control register through the system-register instruction space. Each request carries the five encoding fields, the access direction and a snapshot of the privilege state: the current exception level, whether EL2 is enabled and EL3 exists, the nested-virtualization bits, the EL3 enable for the second fine-grained trap group, and three debug inputs. The debug inputs are the halted state, secure-debug-disable, and an implementation option that sets trap priority.

For each request the gate gives one registered verdict one cycle later. The verdict is one of: not selected, direct access, redirect to a memory slot, trap to EL2, trap to EL3, or undefined. A trap also carries a syndrome class. A redirect also carries the memory offset. A downstream pipeline stage performs the memory access or takes the exception.

Top module: `acc_gate`

## Requirements
- R1: A request is selected only when op0=2'b11, op1=3'b100, CRn=4'b0011, CRm=4'b0001 and op2=3'b001. Any other encoding raises only `res_nosel`, and every other outcome flag, the syndrome and the offset stay 0.
- R2: Outputs are registered. `res_valid` and the verdict appear on the clock edge after the one that samples `req_valid`=1. After a cycle with `req_valid`=0, all outputs are 0.
- R3: When the block is built without the fine-grained trap feature (`FEAT_PRESENT`=0), every selected request is undefined.
- R4: A selected request at EL0 (`cur_el`=0) is undefined.
- R5: At EL1 (`cur_el`=1), if EL2 is enabled and both `nv2` and `nv` are 1, the request is redirected and `res_mem_off` is 12'h1B0.
- R6: At EL1, if EL2 is enabled, `nv`=1 and `nv2`=0, the request traps to EL2. Every other EL1 case is undefined.
- R7: At EL2 (`cur_el`=2), the request is undefined when all of these hold: `halted`, `el3_here`, `sdd`, `sdd_prio` are 1 and `fgt_en2` is 0.
- R8: Otherwise at EL2, if `el3_here`=1 and `fgt_en2`=0, the request is undefined when `halted` and `sdd` are both 1. In every other such case it traps to EL3.
- R9: Every remaining EL2 case is a direct access. Every selected request at EL3 (`cur_el`=3) is a direct access, whatever the other inputs are.
- R10: Exactly one outcome flag is raised per valid response. `res_syndrome` is 6'h18 on either trap and 0 otherwise. `res_mem_off` is nonzero only on a redirect.
- R11: During and after synchronous reset, before any request, all outputs are 0.
- R12: Reads and writes of the same request get the same verdict, and `res_write` repeats the direction of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| el2_en | input | 1 | EL2 enabled in the current security state |
| el3_here | input | 1 | EL3 is implemented |
| nv | input | 1 | Nested-virtualization enable |
| nv2 | input | 1 | Nested-virtualization memory redirection enable |
| fgt_en2 | input | 1 | EL3 enable for the second fine-grained trap group |
| halted | input | 1 | Core is in debug halt |
| sdd | input | 1 | Secure debug disabled |
| sdd_prio | input | 1 | Implementation option: EL3 trap priority under secure-debug-disable |
| res_valid | output | 1 | Verdict valid |
| res_write | output | 1 | Direction of the request that produced this verdict |
| res_nosel | output | 1 | Encoding did not select this register |
| res_direct | output | 1 | Direct register access |
| res_redirect | output | 1 | Redirect to memory slot |
| res_trap_el2 | output | 1 | Trap to EL2 |
| res_trap_el3 | output | 1 | Trap to EL3 |
| res_undef | output | 1 | Undefined instruction |
| res_syndrome | output | 6 | Syndrome class on a trap, otherwise 0 |
| res_mem_off | output | 12 | Memory slot offset on a redirect, otherwise 0 |

## Verification
Every verdict is due exactly one clock edge after the edge that samples the request, because the gate has a single register stage. Each bench task drives a request on a falling edge and holds it for one full cycle. It then checks the outputs on the next falling edge, which falls between the register update and the next sampling edge. It then drops `req_valid` and checks one cycle later that the outputs have returned to 0. The build without the feature is a second instance, driven by the same request and checked on the same cycle.

// File: rtl/acc_gate_pkg.sv
// Shared types for the trap-control register access gate.
// Assumes: exception level is a 2-bit number 0..3.
package acc_gate_pkg;

    // Verdict kinds; the index order matches the one-hot flag vector.
    typedef enum logic [2:0] {
        OUT_NOSEL  = 3'd0,
        OUT_DIRECT = 3'd1,
        OUT_REDIR  = 3'd2,
        OUT_TRAP2  = 3'd3,
        OUT_TRAP3  = 3'd4,
        OUT_UNDEF  = 3'd5
    } outcome_e;

    localparam int NUM_OUTCOMES = 6;

    // Privilege-state snapshot that travels with a request.
    typedef struct packed {
        logic [1:0] el;
        logic       el2_en;
        logic       el3_here;
        logic       nv;
        logic       nv2;
        logic       fgt_en2;
        logic       halted;
        logic       sdd;
        logic       sdd_prio;
    } priv_t;

endpackage

// File: rtl/acc_gate_match.sv
// Encoding matcher: compares the five encoding fields with the
// register's own encoding. Purely combinational.
// Assumes: field widths are fixed by the instruction format.
module acc_gate_match #(
    parameter logic [1:0] SEL_OP0 = 2'b11,
    parameter logic [2:0] SEL_OP1 = 3'b100,
    parameter logic [3:0] SEL_CRN = 4'b0011,
    parameter logic [3:0] SEL_CRM = 4'b0001,
    parameter logic [2:0] SEL_OP2 = 3'b001
) (
    input  logic [1:0] op0,
    input  logic [2:0] op1,
    input  logic [3:0] crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    output logic       hit
);
    localparam int NFIELD = 5;

    logic [NFIELD-1:0] field_eq;

    // Per-field equality.
    always_comb begin
        field_eq[0] = (op0 == SEL_OP0);
        field_eq[1] = (op1 == SEL_OP1);
        field_eq[2] = (crn == SEL_CRN);
        field_eq[3] = (crm == SEL_CRM);
        field_eq[4] = (op2 == SEL_OP2);
    end

    assign hit = &field_eq;
endmodule

// File: rtl/acc_gate_decide.sv
// Priority decision chain: turns a hit plus the privilege snapshot
// into one verdict kind. Purely combinational.
// Assumes: when hit is low the verdict is "not selected" regardless
// of privilege state; FEAT_PRESENT=0 models a build without the feature.
module acc_gate_decide
    import acc_gate_pkg::*;
#(
    parameter bit FEAT_PRESENT = 1'b1
) (
    input  logic     hit,
    input  priv_t    priv,
    output outcome_e verdict
);
    logic el2_redirect;
    logic el2_nv_trap;
    logic hi_undef;
    logic el3_gate;
    logic debug_block;

    // Condition terms shared by the EL1 and EL2 branches.
    always_comb begin
        el2_redirect = priv.el2_en && priv.nv && priv.nv2;
        el2_nv_trap  = priv.el2_en && priv.nv;
        el3_gate     = priv.el3_here && !priv.fgt_en2;
        debug_block  = priv.halted && priv.sdd;
        hi_undef     = debug_block && priv.sdd_prio && el3_gate;
    end

    // Ordered chain, highest priority first.
    always_comb begin
        if (!hit) begin
            verdict = OUT_NOSEL;
        end else if (!FEAT_PRESENT) begin
            verdict = OUT_UNDEF;
        end else begin
            unique case (priv.el)
                2'd0: verdict = OUT_UNDEF;
                2'd1: begin
                    if (el2_redirect)     verdict = OUT_REDIR;
                    else if (el2_nv_trap) verdict = OUT_TRAP2;
                    else                  verdict = OUT_UNDEF;
                end
                2'd2: begin
                    if (hi_undef)         verdict = OUT_UNDEF;
                    else if (el3_gate)    verdict = debug_block ? OUT_UNDEF : OUT_TRAP3;
                    else                  verdict = OUT_DIRECT;
                end
                default: verdict = OUT_DIRECT;
            endcase
        end
    end
endmodule

// File: rtl/acc_gate_out.sv
// Output stage: registers the verdict as a one-hot flag vector,
// the syndrome and the redirect offset.
// Assumes: one verdict per valid cycle; synchronous active-low reset.
module acc_gate_out
    import acc_gate_pkg::*;
#(
    parameter int          SYN_W   = 6,
    parameter int          OFF_W   = 12,
    parameter logic [SYN_W-1:0] TRAP_SYN = 6'h18,
    parameter logic [OFF_W-1:0] MEM_OFF  = 12'h1B0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_write,
    input  outcome_e                verdict,
    output logic                    out_valid,
    output logic                    out_write,
    output logic [NUM_OUTCOMES-1:0] out_flags,
    output logic [SYN_W-1:0]        out_syn,
    output logic [OFF_W-1:0]        out_off
);
    logic [NUM_OUTCOMES-1:0] flags_d;

    // One-hot decode of the verdict, one comparator per outcome.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_OUTCOMES; gi++) begin : g_dec
            assign flags_d[gi] = in_valid && (verdict == outcome_e'(gi));
        end
    endgenerate

    // Single register stage for all response fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_write <= 1'b0;
            out_flags <= '0;
            out_syn   <= '0;
            out_off   <= '0;
        end else begin
            out_valid <= in_valid;
            out_write <= in_valid && in_write;
            out_flags <= flags_d;
            out_syn   <= (in_valid && (verdict == OUT_TRAP2 || verdict == OUT_TRAP3))
                         ? TRAP_SYN : '0;
            out_off   <= (in_valid && verdict == OUT_REDIR) ? MEM_OFF : '0;
        end
    end

    // R10: exactly one flag per valid response, none otherwise.
    a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(out_flags));
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_flags == '0 && out_syn == '0 && out_off == '0));
    // R10: syndrome present exactly on traps.
    a_r10_syn_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_syn != '0) == (out_flags[OUT_TRAP2] || out_flags[OUT_TRAP3]));
    // R5: redirect carries the slot offset.
    a_r5_redirect_off: assert property (@(posedge clk) disable iff (!rst_n)
        out_flags[OUT_REDIR] |-> out_off == MEM_OFF);
endmodule

// File: rtl/acc_gate.sv
// Top of the trap-control register access gate: match, decide,
// register. Verdict is due one cycle after the request.
// Assumes: request fields are stable in the cycle req_valid is high.
module acc_gate
    import acc_gate_pkg::*;
#(
    parameter bit          FEAT_PRESENT = 1'b1,
    parameter int          SYN_W        = 6,
    parameter int          OFF_W        = 12,
    parameter logic [SYN_W-1:0] TRAP_SYN = 6'h18,
    parameter logic [OFF_W-1:0] MEM_OFF  = 12'h1B0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_op0,
    input  logic [2:0]       req_op1,
    input  logic [3:0]       req_crn,
    input  logic [3:0]       req_crm,
    input  logic [2:0]       req_op2,
    input  logic [1:0]       cur_el,
    input  logic             el2_en,
    input  logic             el3_here,
    input  logic             nv,
    input  logic             nv2,
    input  logic             fgt_en2,
    input  logic             halted,
    input  logic             sdd,
    input  logic             sdd_prio,
    output logic             res_valid,
    output logic             res_write,
    output logic             res_nosel,
    output logic             res_direct,
    output logic             res_redirect,
    output logic             res_trap_el2,
    output logic             res_trap_el3,
    output logic             res_undef,
    output logic [SYN_W-1:0] res_syndrome,
    output logic [OFF_W-1:0] res_mem_off
);
    logic                    enc_hit;
    priv_t                   priv;
    outcome_e                verdict;
    logic [NUM_OUTCOMES-1:0] flags;

    // Bundle the privilege snapshot.
    always_comb begin
        priv.el       = cur_el;
        priv.el2_en   = el2_en;
        priv.el3_here = el3_here;
        priv.nv       = nv;
        priv.nv2      = nv2;
        priv.fgt_en2  = fgt_en2;
        priv.halted   = halted;
        priv.sdd      = sdd;
        priv.sdd_prio = sdd_prio;
    end

    acc_gate_match u_match (
        .op0 (req_op0),
        .op1 (req_op1),
        .crn (req_crn),
        .crm (req_crm),
        .op2 (req_op2),
        .hit (enc_hit)
    );

    acc_gate_decide #(.FEAT_PRESENT(FEAT_PRESENT)) u_decide (
        .hit     (enc_hit),
        .priv    (priv),
        .verdict (verdict)
    );

    acc_gate_out #(
        .SYN_W    (SYN_W),
        .OFF_W    (OFF_W),
        .TRAP_SYN (TRAP_SYN),
        .MEM_OFF  (MEM_OFF)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_write  (req_write),
        .verdict   (verdict),
        .out_valid (res_valid),
        .out_write (res_write),
        .out_flags (flags),
        .out_syn   (res_syndrome),
        .out_off   (res_mem_off)
    );

    // Fan the one-hot vector out to named ports.
    assign res_nosel    = flags[OUT_NOSEL];
    assign res_direct   = flags[OUT_DIRECT];
    assign res_redirect = flags[OUT_REDIR];
    assign res_trap_el2 = flags[OUT_TRAP2];
    assign res_trap_el3 = flags[OUT_TRAP3];
    assign res_undef    = flags[OUT_UNDEF];

    // R4: a selected EL0 request is undefined next cycle.
    a_r4_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && enc_hit && cur_el == 2'd0) |=> res_undef);
    // R9: a selected EL3 request is direct next cycle (feature present).
    a_r9_el3_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (FEAT_PRESENT && req_valid && enc_hit && cur_el == 2'd3) |=> res_direct);
    // R1: an unmatched encoding yields only the not-selected flag.
    a_r1_nosel: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !enc_hit) |=> (res_nosel && res_syndrome == '0 && res_mem_off == '0));
    // R2: valid follows the request by one cycle.
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
endmodule

// File: tb/acc_gate_tb_top.sv
// Directed bench: one task per scenario, each checking its own verdict.
module acc_gate_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [1:0] req_op0 = 0;
    logic [2:0] req_op1 = 0;
    logic [3:0] req_crn = 0, req_crm = 0;
    logic [2:0] req_op2 = 0;
    logic [1:0] cur_el = 0;
    logic el2_en = 0, el3_here = 0, nv = 0, nv2 = 0, fgt_en2 = 0;
    logic halted = 0, sdd = 0, sdd_prio = 0;

    logic res_valid, res_write, res_nosel, res_direct, res_redirect;
    logic res_trap_el2, res_trap_el3, res_undef;
    logic [5:0]  res_syndrome;
    logic [11:0] res_mem_off;

    logic nf_valid, nf_write, nf_nosel, nf_direct, nf_redirect;
    logic nf_trap_el2, nf_trap_el3, nf_undef;
    logic [5:0]  nf_syndrome;
    logic [11:0] nf_mem_off;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;  // 250 MHz

    acc_gate dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .cur_el(cur_el), .el2_en(el2_en), .el3_here(el3_here),
        .nv(nv), .nv2(nv2), .fgt_en2(fgt_en2), .halted(halted), .sdd(sdd),
        .sdd_prio(sdd_prio), .res_valid(res_valid), .res_write(res_write),
        .res_nosel(res_nosel), .res_direct(res_direct), .res_redirect(res_redirect),
        .res_trap_el2(res_trap_el2), .res_trap_el3(res_trap_el3), .res_undef(res_undef),
        .res_syndrome(res_syndrome), .res_mem_off(res_mem_off)
    );

    acc_gate #(.FEAT_PRESENT(1'b0)) dut_nofeat_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
        .req_op2(req_op2), .cur_el(cur_el), .el2_en(el2_en), .el3_here(el3_here),
        .nv(nv), .nv2(nv2), .fgt_en2(fgt_en2), .halted(halted), .sdd(sdd),
        .sdd_prio(sdd_prio), .res_valid(nf_valid), .res_write(nf_write),
        .res_nosel(nf_nosel), .res_direct(nf_direct), .res_redirect(nf_redirect),
        .res_trap_el2(nf_trap_el2), .res_trap_el3(nf_trap_el3), .res_undef(nf_undef),
        .res_syndrome(nf_syndrome), .res_mem_off(nf_mem_off)
    );

    // Flag order: {nosel, direct, redirect, trap_el2, trap_el3, undef}
    localparam logic [5:0] F_NOSEL = 6'b100000;
    localparam logic [5:0] F_DIR   = 6'b010000;
    localparam logic [5:0] F_RED   = 6'b001000;
    localparam logic [5:0] F_T2    = 6'b000100;
    localparam logic [5:0] F_T3    = 6'b000010;
    localparam logic [5:0] F_UND   = 6'b000001;

    function automatic logic [5:0] dut_flags();
        return {res_nosel, res_direct, res_redirect, res_trap_el2, res_trap_el3, res_undef};
    endfunction

    task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_priv(input logic [1:0] el, input logic e2, input logic e3,
                            input logic n, input logic n2, input logic fg,
                            input logic h, input logic s, input logic p);
        cur_el = el; el2_en = e2; el3_here = e3; nv = n; nv2 = n2;
        fgt_en2 = fg; halted = h; sdd = s; sdd_prio = p;
    endtask

    task automatic set_enc_match();
        req_op0 = 2'b11; req_op1 = 3'b100; req_crn = 4'b0011;
        req_crm = 4'b0001; req_op2 = 3'b001;
    endtask

    // Drive one request, then check the verdict one edge later and idle after.
    task automatic issue(input string req, input logic wr, input logic [5:0] ef,
                         input logic [5:0] esyn, input logic [11:0] eoff);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, {res_valid, res_write, dut_flags(), esyn == 0 ? res_syndrome : res_syndrome,
                    res_mem_off[8:0]},
                   {1'b1, wr, ef, esyn, eoff[8:0]});
        check(req, {11'd0, res_mem_off}, {11'd0, eoff});
        @(negedge clk);
        check("R2", {res_valid, res_write, dut_flags(), res_syndrome, res_mem_off[8:0]}, 23'd0);
    endtask

    task automatic t_reset();
        check("R11", {res_valid, res_write, dut_flags(), res_syndrome, res_mem_off[8:0]}, 23'd0);
    endtask

    task automatic t_nosel();
        set_enc_match(); req_crm = 4'b0010;
        set_priv(2'd3, 1, 1, 0, 0, 1, 0, 0, 0);
        issue("R1", 1'b0, F_NOSEL, 6'h0, 12'h0);
        set_enc_match(); req_op1 = 3'b000;
        issue("R1", 1'b1, F_NOSEL, 6'h0, 12'h0);
        set_enc_match();
    endtask

    task automatic t_el0();
        set_priv(2'd0, 1, 1, 1, 1, 1, 0, 0, 0);
        issue("R4", 1'b0, F_UND, 6'h0, 12'h0);
        issue("R12", 1'b1, F_UND, 6'h0, 12'h0);
    endtask

    task automatic t_el1();
        set_priv(2'd1, 1, 0, 1, 1, 0, 0, 0, 0);
        issue("R5", 1'b1, F_RED, 6'h0, 12'h1B0);
        issue("R12", 1'b0, F_RED, 6'h0, 12'h1B0);
        set_priv(2'd1, 1, 1, 1, 0, 0, 0, 0, 0);
        issue("R6", 1'b0, F_T2, 6'h18, 12'h0);
        set_priv(2'd1, 1, 1, 0, 1, 0, 0, 0, 0);
        issue("R6", 1'b0, F_UND, 6'h0, 12'h0);
        set_priv(2'd1, 0, 1, 1, 1, 0, 0, 0, 0);
        issue("R6", 1'b1, F_UND, 6'h0, 12'h0);
    endtask

    task automatic t_el2();
        set_priv(2'd2, 1, 1, 0, 0, 0, 1, 1, 1);
        issue("R7", 1'b0, F_UND, 6'h0, 12'h0);
        set_priv(2'd2, 1, 1, 0, 0, 0, 1, 1, 0);
        issue("R8", 1'b1, F_UND, 6'h0, 12'h0);
        set_priv(2'd2, 1, 1, 0, 0, 0, 1, 0, 1);
        issue("R8", 1'b0, F_T3, 6'h18, 12'h0);
        set_priv(2'd2, 1, 1, 1, 1, 0, 0, 1, 0);
        issue("R8", 1'b1, F_T3, 6'h18, 12'h0);
        set_priv(2'd2, 1, 1, 0, 0, 1, 1, 1, 1);
        issue("R9", 1'b0, F_DIR, 6'h0, 12'h0);
        set_priv(2'd2, 1, 0, 0, 0, 0, 1, 1, 1);
        issue("R9", 1'b1, F_DIR, 6'h0, 12'h0);
    endtask

    task automatic t_el3();
        set_priv(2'd3, 0, 1, 1, 1, 0, 1, 1, 1);
        issue("R9", 1'b0, F_DIR, 6'h0, 12'h0);
        set_priv(2'd3, 1, 0, 0, 0, 1, 0, 0, 0);
        issue("R10", 1'b1, F_DIR, 6'h0, 12'h0);
    endtask

    task automatic t_nofeat();
        set_enc_match();
        set_priv(2'd3, 1, 1, 0, 0, 1, 0, 0, 0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R3", {17'd0, nf_valid, nf_nosel, nf_direct, nf_redirect, nf_trap_el3, nf_undef},
                    {17'd0, 6'b100001});
        check("R3", {11'd0, nf_mem_off}, 23'd0);
        set_priv(2'd1, 1, 0, 1, 1, 0, 0, 0, 0);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R3", {17'd0, nf_undef, nf_redirect, nf_trap_el2, nf_syndrome[2:0]}, {17'd0, 6'b100000});
        @(negedge clk);
    endtask

    initial begin
        set_enc_match();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nosel();
        t_el0();
        t_el1();
        t_el2();
        t_el3();
        t_nofeat();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule